// File: doc/BRIEF.md
# Conditional instruction skip unit

This unit sits in the instruction sequencer of a fixed-program audio DSP core, where the whole program runs once per sample in a straight line. It looks at each issued instruction word. When it sees a conditional-skip instruction, it compares the instruction's condition mask with five condition flags. The flags come from the current accumulator, the previous accumulator and a first-pass status bit. If every flag selected by the mask is true, the unit suppresses the next N valid instructions. Those instructions keep their issue slots but execute as no-ops, so the number of cycles per sample never changes.

The sequencer pulses `pass_end` when a program pass completes and `prog_load` when a new program is loaded. The first-pass flag stays set until the first pass ends. This lets initialization code be skipped on every later sample.

Top module: `skip_unit`

## Requirements
- R1: An instruction counts as a skip instruction only when `insn_valid` is high, bits 4:0 equal 5'b10001 and bits 20:5 are all zero. Bits 31:27 hold the condition mask and bits 26:21 hold the skip count N.
- R2: `flags` is {RUN, ZRC, ZRO, GEZ, NEG} in bits 4 down to 0. ZRC is the XOR of the sign bits of `acc` and `acc_prev`. ZRO means `acc` is zero. GEZ means the sign bit of `acc` is clear. NEG means the sign bit of `acc` is set.
- R3: The skip is taken when every flag whose mask bit is 1 is asserted. Several mask bits may be combined. A mask of zero makes the skip unconditional.
- R4: A taken skip raises `suppress` for exactly the next N cycles in which `insn_valid` is high. Cycles with `insn_valid` low neither consume the count nor show `suppress`. The skip instruction itself is not suppressed.
- R5: A skip instruction that arrives while a skip is still in progress is itself suppressed and does not reload the count.
- R6: A `pass_end` pulse clears any remaining skip count, so suppression stops from the next cycle.
- R7: RUN is 1 after reset and after `prog_load`. It becomes 0 in the cycle after `pass_end`. When `prog_load` and `pass_end` arrive together, `prog_load` wins.
- R8: A skip instruction with N equal to 0, an instruction word that is not a skip instruction, and a skip word presented with `insn_valid` low all cause no suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_load | input | 1 | Program-load pulse, sets RUN |
| pass_end | input | 1 | End-of-pass pulse |
| insn_valid | input | 1 | Instruction issue strobe |
| insn_word | input | 32 | Instruction being issued |
| acc | input | 24 | Current accumulator, two's complement |
| acc_prev | input | 24 | Previous accumulator, two's complement |
| suppress | output | 1 | Current instruction is to execute as a no-op |
| flags | output | 5 | Condition flags {RUN, ZRC, ZRO, GEZ, NEG} |

## Verification
The mask test uses a positive, a negative and a zero accumulator against single-flag masks. This separates GEZ, ZRO and NEG and shows that a false flag blocks the skip. The combined ZRC-with-NEG mask is tried with both a sign change and a steady negative sign, which shows that the flags are ANDed rather than ORed. Skip runs are interleaved with idle cycles, nested skip words and an end-of-pass pulse. These show that only valid slots consume the count, that a nested skip does not reload it, and that the pass boundary cuts a skip short. RUN-masked skips before and after the first pass end, and again after a reload, show the one-shot behaviour of the first-pass flag.

// File: rtl/skip_unit.sv
module skip_unit #(
  parameter int ACC_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_load,
  input  logic             pass_end,
  input  logic             insn_valid,
  input  logic [31:0]      insn_word,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] acc_prev,
  output logic             suppress,
  output logic [4:0]       flags
);

  localparam logic [4:0] OPC_SKIP = 5'b10001;
  localparam int CNT_LSB = 21;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  wire [4:0]       mask   = insn_word[31:27];
  wire [CNT_W-1:0] count  = insn_word[CNT_LSB +: CNT_W];
  wire             is_skp = insn_valid && insn_word[4:0] == OPC_SKIP && insn_word[20:5] == '0;
  wire             busy   = cnt_q != '0;

  wire neg = acc[ACC_W-1];
  wire gez = ~acc[ACC_W-1];
  wire zro = acc == '0;
  wire zrc = acc[ACC_W-1] ^ acc_prev[ACC_W-1];

  assign flags    = {run_q, zrc, zro, gez, neg};
  assign suppress = insn_valid && busy;

  wire cond_ok = (flags & mask) == mask;
  wire take    = is_skp && !busy && cond_ok && count != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (pass_end)          cnt_q <= '0;
    else if (take)              cnt_q <= count;
    else if (insn_valid && busy) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= 1'b1;
    else if (prog_load) run_q <= 1'b1;
    else if (pass_end)  run_q <= 1'b0;
  end

  assert_load_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !pass_end |=> cnt_q == $past(count));

  assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > $past(cnt_q)) |-> $past(take));

  assert_pass_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> !suppress);

  assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end && !prog_load |=> !flags[4]);

  assert_run_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_load |=> flags[4]);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> !suppress);

endmodule

// File: tb/skip_unit_bench.sv
module skip_unit_bench;
  logic clk = 0, rst_n = 0, prog_load = 0, pass_end = 0, insn_valid = 0;
  logic [31:0] insn_word = '0;
  logic [23:0] acc = '0, acc_prev = '0;
  logic suppress;
  logic [4:0] flags;
  int n_chk = 0, n_fail = 0;
  logic s_sup;
  logic [4:0] s_flags;

  localparam logic [4:0] M_RUN = 5'h10, M_ZRC = 5'h08, M_ZRO = 5'h04, M_GEZ = 5'h02, M_NEG = 5'h01;
  localparam logic [31:0] NOP = 32'h0;

  always #10 clk = ~clk;

  skip_unit u_skip_unit (.clk, .rst_n, .prog_load, .pass_end, .insn_valid, .insn_word,
    .acc, .acc_prev, .suppress, .flags);

  function automatic logic [31:0] skp(input logic [4:0] m, input logic [5:0] n);
    return {m, n, 16'h0, 5'b10001};
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [23:0] a, input logic [23:0] p,
                      input logic pe = 0, input logic ld = 0);
    @(negedge clk);
    insn_valid = v; insn_word = w; acc = a; acc_prev = p; pass_end = pe; prog_load = ld;
    #2;
    s_sup = suppress; s_flags = flags;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    step(1, NOP, 24'd5, 24'd5);
    chk(s_sup, 0, "R8 reset no suppress");
    chk(s_flags, 5'b10010, "R2 R7 reset flags");
  endtask

  task automatic t_flags;
    step(0, NOP, 24'd0, 24'd0);
    chk(s_flags[3:0], 4'b0110, "R2 zero acc");
    step(0, NOP, 24'h800000, 24'd1);
    chk(s_flags[3:0], 4'b1001, "R2 negative with crossing");
    step(0, NOP, 24'd7, 24'hFFFFFF);
    chk(s_flags[3:0], 4'b1010, "R2 positive with crossing");
  endtask

  task automatic t_gez_skip;
    step(1, skp(M_GEZ, 6'd2), 24'd100, 24'd100);
    chk(s_sup, 0, "R4 skip word itself");
    step(1, NOP, 24'd1, 24'd1); chk(s_sup, 1, "R4 first skipped");
    step(0, NOP, 24'd1, 24'd1); chk(s_sup, 0, "R4 idle slot");
    step(1, NOP, 24'd1, 24'd1); chk(s_sup, 1, "R4 second skipped");
    step(1, NOP, 24'd1, 24'd1); chk(s_sup, 0, "R4 count exhausted");
  endtask

  task automatic t_masks;
    step(1, skp(M_GEZ, 6'd1), 24'hFFFFF0, 24'hFFFFF0);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R3 GEZ false");
    step(1, skp(M_ZRO, 6'd1), 24'd0, 24'd0);
    step(1, NOP, 0, 0); chk(s_sup, 1, "R3 ZRO true");
    step(1, skp(M_ZRC | M_NEG, 6'd1), 24'hFFFF00, 24'd3);
    step(1, NOP, 0, 0); chk(s_sup, 1, "R3 ZRC and NEG both");
    step(1, skp(M_ZRC | M_NEG, 6'd1), 24'hFFFF00, 24'hFFFF00);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R3 NEG without ZRC");
    step(1, skp(5'h00, 6'd1), 24'hFFFF00, 24'd0);
    step(1, NOP, 0, 0); chk(s_sup, 1, "R3 zero mask unconditional");
  endtask

  task automatic t_nested;
    step(1, skp(5'h00, 6'd2), 0, 0);
    step(1, skp(5'h00, 6'd5), 0, 0); chk(s_sup, 1, "R5 nested skip suppressed");
    step(1, NOP, 0, 0); chk(s_sup, 1, "R5 original count continues");
    step(1, NOP, 0, 0); chk(s_sup, 0, "R5 no reload");
  endtask

  task automatic t_invalid;
    step(1, skp(5'h00, 6'd0), 0, 0);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R8 N zero");
    step(0, skp(5'h00, 6'd3), 0, 0);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R8 valid low");
    step(1, skp(5'h00, 6'd3) | 32'h0000_0100, 0, 0);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R1 reserved bits set");
    step(1, {5'h00, 6'd3, 16'h0, 5'b10000}, 0, 0);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R1 other opcode");
  endtask

  task automatic t_run;
    step(1, skp(M_RUN, 6'd1), 24'd1, 24'd1);
    step(1, NOP, 0, 0); chk(s_sup, 1, "R7 RUN skip first pass");
    step(1, skp(5'h00, 6'd10), 0, 0);
    step(1, NOP, 0, 0); chk(s_sup, 1, "R6 skipping before end");
    step(1, NOP, 0, 0, 1); chk(s_sup, 1, "R6 end slot still skipped");
    step(1, NOP, 0, 0); chk(s_sup, 0, "R6 count cleared");
    chk(s_flags[4], 0, "R7 RUN cleared");
    step(1, skp(M_RUN, 6'd1), 24'd1, 24'd1);
    step(1, NOP, 0, 0); chk(s_sup, 0, "R7 RUN skip later pass");
    step(0, NOP, 0, 0, 1, 1);
    step(0, NOP, 0, 0); chk(s_flags[4], 1, "R7 load wins over end");
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_flags();
    t_gez_skip();
    t_masks();
    t_nested();
    t_invalid();
    t_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule